// File: doc/BRIEF.md
# Eight-Channel Block Copy Engine

The block moves bytes between a 24-bit banked memory space and a 256-byte window of peripheral registers. That window sits at the fixed page 0x21 of the same space. Each of the eight channels keeps its own settings, which the CPU can read and write through a byte-wide register port:

- a control byte
- a peripheral target
- a 16-bit source pointer and a source bank
- a 16-bit byte count
- a few spare fields

A CPU write to the start address carries a channel mask. Every channel named in that mask then runs, lowest number first, and each channel finishes its whole count before the next one begins.

Every byte takes one read and then one write on a single memory port. The request side uses a valid/ready handshake. Once `mem_valid` is raised, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until a cycle in which `mem_ready` is high. The slave can stall for as long as it needs. After an accepted read, the engine waits for exactly one `mem_rvalid` pulse, and it never applies back-pressure to that response. The `busy` output stays high while a batch of channels is being worked through.

Top module: `blkdma_engine`

## Requirements
- R1: After reset, `busy` and `mem_valid` are 0 and every channel register reads 0.
- R2: Channel n (0..7) answers at addresses 0x43n0..0x43nA. Address bits [6:4] select the channel. The offsets are: 0 control, 1 target, 2/3 source low/high, 4 bank, 5/6 count low/high, 7 spare bank, 8/9 spare pointer low/high, A spare byte. Every field reads back as written, and that includes control bit 5, which has no function. Reads of offsets B..F, of addresses with bit 7 set, and of the start address 0x420B all return 0.
- R3: The peripheral address is {0x00, 0x21, target + offset}, with the low byte wrapping modulo 256.
- R4: Control bit 3 (fixed) holds the source pointer. Otherwise control bit 4 steps it by -1 when set and by +1 when clear. Only the 16-bit part ever moves, so the pointer wraps inside its bank. The final value can be read back after the run.
- R5: When control bit 7 is 0, the engine reads the source {bank, pointer} and writes the peripheral. When it is 1, it reads the peripheral and writes the source.
- R6: Control bits 2:0 choose a repeating offset unit:
  - mode 0: {0}
  - modes 1, 5: {0,1} and {0,1,0,1}
  - modes 2, 6: {0,0}
  - modes 3, 7: {0,0,1,1}
  - mode 4: {0,1,2,3}

  Every unit restarts at its first entry. A run stops as soon as its count is used up, even if that leaves a unit incomplete.
- R7: The count drops by one for each byte and the channel stops when it reaches zero. A starting count of 0 moves 65536 bytes. After n bytes the count reads 0x10000 - n.
- R8: A write to 0x420B starts every channel whose bit is set, in ascending order. A write to that address while `busy` is high has no effect.
- R9: The engine works on a private copy of the active channel's settings. It writes the source pointer and count back after each byte. If a CPU write to those fields lands in the same cycle as a write-back, the write-back wins, and the run is unaffected either way.
- R10: A stalled request holds steady. Each byte is one read, then one response, then one write carrying the returned data. `busy` rises in the cycle after the start write and drops within two cycles of the last write handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_addr | input | 16 | CPU register address |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | CPU read data (combinational from reg_addr) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 24 | Memory request address |
| mem_wdata | output | 8 | Write data |
| mem_rvalid | input | 1 | Read response valid, one per accepted read |
| mem_rdata | input | 8 | Read response data |
| busy | output | 1 | A batch of channels is in progress |

## Verification
Two things can land in one clock: a CPU register write and the engine's per-byte write-back of the active channel's pointer and count. The bench provokes this by watching for a write request with ready held high, then driving a count write to the running channel in that same cycle. It then confirms three things: the scoreboard still sees the full, unaltered byte sequence, and the count and pointer read back the values the engine left. A second case that overlaps is a start write issued while a run is in progress. That is judged by the absence of any unexpected transfer and by the untouched count of the channel it named.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  localparam logic [7:0]  WIN_PAGE    = 8'h43;
  localparam logic [15:0] START_ADDR  = 16'h420B;
  localparam logic [7:0]  PERIPH_PAGE = 8'h21;

  localparam logic [3:0] OFS_CTL   = 4'h0;
  localparam logic [3:0] OFS_TGT   = 4'h1;
  localparam logic [3:0] OFS_SRCL  = 4'h2;
  localparam logic [3:0] OFS_SRCH  = 4'h3;
  localparam logic [3:0] OFS_BANK  = 4'h4;
  localparam logic [3:0] OFS_CNTL  = 4'h5;
  localparam logic [3:0] OFS_CNTH  = 4'h6;
  localparam logic [3:0] OFS_XBANK = 4'h7;
  localparam logic [3:0] OFS_PTRL  = 4'h8;
  localparam logic [3:0] OFS_PTRH  = 4'h9;
  localparam logic [3:0] OFS_AUX   = 4'hA;

  typedef struct packed {
    logic       to_mem;
    logic       indirect;
    logic       spare;
    logic       down;
    logic       hold;
    logic [2:0] mode;
  } ctl_t;

  typedef struct packed {
    ctl_t        ctl;
    logic [7:0]  tgt;
    logic [15:0] src;
    logic [7:0]  bank;
    logic [15:0] cnt;
    logic [7:0]  xbank;
    logic [15:0] ptr;
    logic [7:0]  aux;
  } chan_cfg_t;

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_RD, S_WAIT, S_WR} seq_st_t;

  function automatic logic [2:0] unit_len(input logic [2:0] mode);
    case (mode)
      3'd0:                unit_len = 3'd1;
      3'd1, 3'd2, 3'd6:    unit_len = 3'd2;
      default:             unit_len = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] pattern_offset(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd1, 3'd5: pattern_offset = {1'b0, idx[0]};
      3'd3, 3'd7: pattern_offset = {1'b0, idx[1]};
      3'd4:       pattern_offset = idx;
      default:    pattern_offset = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
  import blkdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  input  logic [15:0]     cpu_addr,
  input  logic [7:0]      cpu_wdata,
  output logic [7:0]      cpu_rdata,
  input  logic            upd_en,
  input  logic [CH_W-1:0] upd_ch,
  input  logic [15:0]     upd_src,
  input  logic [15:0]     upd_cnt,
  output chan_cfg_t       cfg [NCH]
);

  logic            win_hit;
  logic [3:0]      ofs;
  logic [CH_W-1:0] rsel;

  assign ofs     = cpu_addr[3:0];
  assign rsel    = cpu_addr[4 +: CH_W];
  assign win_hit = (cpu_addr[15:8] == WIN_PAGE) && !cpu_addr[7] &&
                   (int'(cpu_addr[6:4]) < NCH);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t r;
    logic      wr_me;
    assign wr_me  = cpu_we && win_hit && (int'(cpu_addr[6:4]) == c);
    assign cfg[c] = r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else begin
        if (wr_me) begin
          case (ofs)
            OFS_CTL:   r.ctl        <= ctl_t'(cpu_wdata);
            OFS_TGT:   r.tgt        <= cpu_wdata;
            OFS_SRCL:  r.src[7:0]   <= cpu_wdata;
            OFS_SRCH:  r.src[15:8]  <= cpu_wdata;
            OFS_BANK:  r.bank       <= cpu_wdata;
            OFS_CNTL:  r.cnt[7:0]   <= cpu_wdata;
            OFS_CNTH:  r.cnt[15:8]  <= cpu_wdata;
            OFS_XBANK: r.xbank      <= cpu_wdata;
            OFS_PTRL:  r.ptr[7:0]   <= cpu_wdata;
            OFS_PTRH:  r.ptr[15:8]  <= cpu_wdata;
            OFS_AUX:   r.aux        <= cpu_wdata;
            default:   ;
          endcase
        end
        // engine write-back comes last so it takes priority on a collision
        if (upd_en && (upd_ch == CH_W'(c))) begin
          r.src <= upd_src;
          r.cnt <= upd_cnt;
        end
      end
    end
  end

  always_comb begin
    chan_cfg_t rc;
    rc        = cfg[rsel];
    cpu_rdata = '0;
    if (win_hit) begin
      case (ofs)
        OFS_CTL:   cpu_rdata = rc.ctl;
        OFS_TGT:   cpu_rdata = rc.tgt;
        OFS_SRCL:  cpu_rdata = rc.src[7:0];
        OFS_SRCH:  cpu_rdata = rc.src[15:8];
        OFS_BANK:  cpu_rdata = rc.bank;
        OFS_CNTL:  cpu_rdata = rc.cnt[7:0];
        OFS_CNTH:  cpu_rdata = rc.cnt[15:8];
        OFS_XBANK: cpu_rdata = rc.xbank;
        OFS_PTRL:  cpu_rdata = rc.ptr[7:0];
        OFS_PTRH:  cpu_rdata = rc.ptr[15:8];
        OFS_AUX:   cpu_rdata = rc.aux;
        default:   cpu_rdata = '0;
      endcase
    end
  end

  // R9: a write-back must be visible in the stored count on the next cycle
  a_r9_writeback_wins: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (cfg[$past(upd_ch)].cnt == $past(upd_cnt)));

endmodule

// File: rtl/blkdma_addr.sv
module blkdma_addr
  import blkdma_pkg::*;
(
  input  ctl_t        ctl,
  input  logic [7:0]  tgt,
  input  logic [7:0]  bank,
  input  logic [15:0] src,
  input  logic [1:0]  idx,
  output logic [23:0] rd_addr,
  output logic [23:0] wr_addr,
  output logic [15:0] nxt_src,
  output logic [1:0]  nxt_idx
);

  logic [7:0]  per_lo;
  logic [23:0] per_full;
  logic [23:0] mem_full;
  logic [2:0]  idx_inc;

  assign per_lo   = tgt + {6'd0, pattern_offset(ctl.mode, idx)};
  assign per_full = {8'h00, PERIPH_PAGE, per_lo};
  assign mem_full = {bank, src};

  assign rd_addr = ctl.to_mem ? per_full : mem_full;
  assign wr_addr = ctl.to_mem ? mem_full : per_full;

  always_comb begin
    if (ctl.hold)      nxt_src = src;
    else if (ctl.down) nxt_src = src - 16'd1;
    else               nxt_src = src + 16'd1;
  end

  assign idx_inc = {1'b0, idx} + 3'd1;
  assign nxt_idx = (idx_inc >= unit_len(ctl.mode)) ? 2'd0 : idx_inc[1:0];

endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
  import blkdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      start_mask,
  input  chan_cfg_t       cfg [NCH],
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [23:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic            mem_rvalid,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            upd_en,
  output logic [CH_W-1:0] upd_ch,
  output logic [15:0]     upd_src,
  output logic [15:0]     upd_cnt
);

  seq_st_t         state;
  logic [NCH-1:0]  pending;
  logic [CH_W-1:0] cur;
  ctl_t            w_ctl;
  logic [7:0]      w_tgt;
  logic [7:0]      w_bank;
  logic [15:0]     w_src;
  logic [15:0]     w_cnt;
  logic [1:0]      idx;
  logic [7:0]      rbuf;

  logic            found;
  logic [CH_W-1:0] pick_ch;
  logic [23:0]     rd_addr;
  logic [23:0]     wr_addr;
  logic [15:0]     nxt_src;
  logic [1:0]      nxt_idx;
  logic            go;

  assign go = start && (|start_mask[NCH-1:0]);

  always_comb begin
    found   = 1'b0;
    pick_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found   = 1'b1;
        pick_ch = CH_W'(i);
      end
    end
  end

  blkdma_addr u_addr (
    .ctl     (w_ctl),
    .tgt     (w_tgt),
    .bank    (w_bank),
    .src     (w_src),
    .idx     (idx),
    .rd_addr (rd_addr),
    .wr_addr (wr_addr),
    .nxt_src (nxt_src),
    .nxt_idx (nxt_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pending <= '0;
      cur     <= '0;
      w_ctl   <= '0;
      w_tgt   <= '0;
      w_bank  <= '0;
      w_src   <= '0;
      w_cnt   <= '0;
      idx     <= '0;
      rbuf    <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          pending <= start_mask[NCH-1:0];
          state   <= S_PICK;
        end
        S_PICK: begin
          if (!found) begin
            state <= S_IDLE;
          end else begin
            pending[pick_ch] <= 1'b0;
            cur    <= pick_ch;
            w_ctl  <= cfg[pick_ch].ctl;
            w_tgt  <= cfg[pick_ch].tgt;
            w_bank <= cfg[pick_ch].bank;
            w_src  <= cfg[pick_ch].src;
            w_cnt  <= cfg[pick_ch].cnt;
            idx    <= '0;
            state  <= S_RD;
          end
        end
        S_RD: if (mem_ready) state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          rbuf  <= mem_rdata;
          state <= S_WR;
        end
        S_WR: if (mem_ready) begin
          w_src <= nxt_src;
          w_cnt <= w_cnt - 16'd1;
          idx   <= nxt_idx;
          state <= (w_cnt == 16'd1) ? S_PICK : S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_valid = (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = mem_we ? wr_addr : rd_addr;
  assign mem_wdata = rbuf;
  assign busy      = (state != S_IDLE);
  assign upd_en    = (state == S_WR) && mem_ready;
  assign upd_ch    = cur;
  assign upd_src   = nxt_src;
  assign upd_cnt   = w_cnt - 16'd1;

  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  a_r3_periph_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (mem_we != w_ctl.to_mem) |-> mem_addr[23:8] == {8'h00, PERIPH_PAGE});

  a_r7_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_ready && (w_cnt == 16'd1) |=> !mem_valid);

  a_r6_unit_idx: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, idx} < unit_len(w_ctl.mode)));

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && go |=> busy);

endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [15:0] reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_rvalid,
  input  logic [7:0]  mem_rdata,
  output logic        busy
);

  chan_cfg_t       cfg [NCH];
  logic            upd_en;
  logic [CH_W-1:0] upd_ch;
  logic [15:0]     upd_src;
  logic [15:0]     upd_cnt;
  logic            start;

  assign start = reg_we && (reg_addr == START_ADDR);

  blkdma_regs #(.NCH(NCH), .CH_W(CH_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (reg_we),
    .cpu_addr  (reg_addr),
    .cpu_wdata (reg_wdata),
    .cpu_rdata (reg_rdata),
    .upd_en    (upd_en),
    .upd_ch    (upd_ch),
    .upd_src   (upd_src),
    .upd_cnt   (upd_cnt),
    .cfg       (cfg)
  );

  blkdma_seq #(.NCH(NCH), .CH_W(CH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_mask (reg_wdata),
    .cfg        (cfg),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .upd_en     (upd_en),
    .upd_ch     (upd_ch),
    .upd_src    (upd_src),
    .upd_cnt    (upd_cnt)
  );

endmodule

// File: tb/blkdma_engine_test.sv
module blkdma_engine_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  bit stall_en = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    string       tag;
    logic [23:0] rd;
    logic [23:0] wr;
  } item_t;
  item_t sb[$];

  logic        rv_flag = 1'b0;
  logic [23:0] rv_addr = '0;
  logic [23:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkdma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy)
  );

  function automatic logic [7:0] memfn(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic check(input string tag, input string what, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      rv_flag    = 1'b0;
      mem_rvalid = 1'b0;
      mem_ready  = 1'b1;
    end else begin
      mem_rvalid = rv_flag;
      mem_rdata  = rv_flag ? memfn(rv_addr) : 8'h00;
      rv_flag    = 1'b0;
      mem_ready  = stall_en ? (($urandom % 3) != 0) : 1'b1;
      if (mem_valid && mem_ready) begin
        if (!mem_we) begin
          rv_flag = 1'b1;
          rv_addr = mem_addr;
          last_rd = mem_addr;
        end else begin
          wr_seen++;
          if (sb.size() == 0) begin
            check("R10", "unexpected write", {24'h0, mem_addr}, 48'hFFFFFF_FFFFFF);
          end else begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, "read addr", {24'h0, last_rd}, {24'h0, it.rd});
            check(it.tag, "write addr", {24'h0, mem_addr}, {24'h0, it.wr});
            check("R10", "write data", {40'h0, mem_wdata}, {40'h0, memfn(last_rd)});
          end
        end
      end
    end
  end

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd_reg(a, d);
    check(tag, $sformatf("reg %h", a), {40'h0, d}, {40'h0, exp});
  endtask

  task automatic cfg_ch(input int ch, input logic [7:0] ctl, input logic [7:0] tgt,
                        input logic [15:0] src, input logic [7:0] bank, input logic [15:0] cnt);
    logic [15:0] base;
    base = 16'h4300 | 16'(ch << 4);
    wr_reg(base | 16'h0, ctl);
    wr_reg(base | 16'h1, tgt);
    wr_reg(base | 16'h2, src[7:0]);
    wr_reg(base | 16'h3, src[15:8]);
    wr_reg(base | 16'h4, bank);
    wr_reg(base | 16'h5, cnt[7:0]);
    wr_reg(base | 16'h6, cnt[15:8]);
  endtask

  function automatic int ulen(input logic [2:0] m);
    if (m == 3'd0) return 1;
    if (m == 3'd1 || m == 3'd2 || m == 3'd6) return 2;
    return 4;
  endfunction

  function automatic logic [7:0] offs(input logic [2:0] m, input int i);
    case (m)
      3'd1: return (i == 1) ? 8'd1 : 8'd0;
      3'd3, 3'd7: return (i >= 2) ? 8'd1 : 8'd0;
      3'd4: return 8'(i);
      3'd5: return (i % 2 == 1) ? 8'd1 : 8'd0;
      default: return 8'd0;
    endcase
  endfunction

  // driver: predicts the byte sequence of a run and pushes it into the scoreboard
  task automatic push_run(input string tag, input logic [7:0] ctl, input logic [7:0] tgt,
                          input logic [15:0] src, input logic [7:0] bank, input int n,
                          output logic [15:0] fin);
    logic [15:0] s;
    s = src;
    for (int k = 0; k < n; k++) begin
      item_t it;
      logic [23:0] per, mem;
      per = {8'h00, 8'h21, 8'(tgt + offs(ctl[2:0], k % ulen(ctl[2:0])))};
      mem = {bank, s};
      it.tag = tag;
      it.rd  = ctl[7] ? per : mem;
      it.wr  = ctl[7] ? mem : per;
      sb.push_back(it);
      if (!ctl[3]) s = ctl[4] ? s - 16'd1 : s + 16'd1;
    end
    fin = s;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(tag, "scoreboard drained", 48'(sb.size()), 48'd0);
  endtask

  task automatic expect_src(input string tag, input int ch, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rd_reg(16'h4302 | 16'(ch << 4), lo);
    rd_reg(16'h4303 | 16'(ch << 4), hi);
    check(tag, $sformatf("ch%0d final source", ch), {32'h0, hi, lo}, {32'h0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] f1, f2, f3, f4, f5, f6, f7, fx;
    logic [7:0]  d;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1", "busy", 48'(busy), 48'd0);
    check("R1", "mem_valid", 48'(mem_valid), 48'd0);
    expect_rd("R1", 16'h4375, 8'h00);
    expect_rd("R1", 16'h4300, 8'h00);

    // R2 register map on channel 5, spare bit in control
    for (int o = 0; o <= 10; o++) wr_reg(16'h4350 | 16'(o), 8'(8'h31 + o * 8'h17));
    wr_reg(16'h4350, 8'hA5);
    expect_rd("R2", 16'h4350, 8'hA5);
    for (int o = 1; o <= 10; o++) expect_rd("R2", 16'h4350 | 16'(o), 8'(8'h31 + o * 8'h17));
    expect_rd("R2", 16'h435B, 8'h00);
    expect_rd("R2", 16'h43D0, 8'h00);
    wr_reg(16'h420B, 8'h00);
    expect_rd("R2", 16'h420B, 8'h00);
    check("R8", "mask zero starts nothing", 48'(busy), 48'd0);

    // single channel, mode 0, increment
    cfg_ch(0, 8'h00, 8'h18, 16'h1000, 8'h7E, 16'd5);
    push_run("R4", 8'h00, 8'h18, 16'h1000, 8'h7E, 5, f1);
    wr_reg(16'h420B, 8'h01);
    check("R10", "busy after start", 48'(busy), 48'd1);
    wait_idle("R7");
    expect_src("R4", 0, f1);
    expect_rd("R7", 16'h4305, 8'h00);
    expect_rd("R7", 16'h4306, 8'h00);

    // several channels in one batch, ascending service order, patterns
    cfg_ch(1, 8'h01, 8'hFF, 16'h0100, 8'h01, 16'd5);
    cfg_ch(2, 8'h03, 8'hFE, 16'h0200, 8'h02, 16'd6);
    cfg_ch(3, 8'h14, 8'h20, 16'h0310, 8'h03, 16'd7);
    cfg_ch(4, 8'h0D, 8'h30, 16'h0400, 8'h04, 16'd4);
    push_run("R6", 8'h01, 8'hFF, 16'h0100, 8'h01, 5, f1);
    push_run("R8", 8'h03, 8'hFE, 16'h0200, 8'h02, 6, f2);
    push_run("R6", 8'h14, 8'h20, 16'h0310, 8'h03, 7, f3);
    push_run("R4", 8'h0D, 8'h30, 16'h0400, 8'h04, 4, f4);
    wr_reg(16'h420B, 8'h1E);
    wait_idle("R8");
    expect_src("R4", 3, f3);
    expect_src("R4", 4, f4);

    // direction, bank wrap in both senses, modes 2/6/7, with stalls
    stall_en = 1'b1;
    cfg_ch(5, 8'h86, 8'h40, 16'h5000, 8'h7F, 16'd3);
    cfg_ch(6, 8'h02, 8'h50, 16'hFFFE, 8'h12, 16'd4);
    cfg_ch(7, 8'h17, 8'h60, 16'h0001, 8'h13, 16'd3);
    push_run("R5", 8'h86, 8'h40, 16'h5000, 8'h7F, 3, f5);
    push_run("R4", 8'h02, 8'h50, 16'hFFFE, 8'h12, 4, f6);
    push_run("R4", 8'h17, 8'h60, 16'h0001, 8'h13, 3, f7);
    wr_reg(16'h420B, 8'hE0);
    wait_idle("R10");
    stall_en = 1'b0;
    expect_src("R4", 6, 16'h0002);
    expect_src("R4", 7, 16'hFFFE);
    expect_rd("R4", 16'h4364, 8'h12);

    // start write while busy is ignored
    cfg_ch(0, 8'h00, 8'h08, 16'h0800, 8'h00, 16'd3);
    cfg_ch(1, 8'h00, 8'h09, 16'h0900, 8'h00, 16'd2);
    push_run("R8", 8'h00, 8'h08, 16'h0800, 8'h00, 3, fx);
    wr_reg(16'h420B, 8'h01);
    wr_reg(16'h420B, 8'h02);
    wait_idle("R8");
    expect_rd("R8", 16'h4315, 8'h02);

    // R9 collision: CPU count write in the write-back cycle
    cfg_ch(0, 8'h00, 8'h0A, 16'h0A00, 8'h05, 16'd6);
    push_run("R9", 8'h00, 8'h0A, 16'h0A00, 8'h05, 6, fx);
    wr_reg(16'h420B, 8'h01);
    while (!(mem_valid && mem_we)) @(negedge clk);
    reg_we = 1'b1; reg_addr = 16'h4305; reg_wdata = 8'h01;
    @(negedge clk);
    reg_we = 1'b0;
    wait_idle("R9");
    expect_rd("R9", 16'h4305, 8'h00);
    expect_src("R9", 0, fx);

    // R7 count zero means 65536: observe the count passing through 0xFFFB
    cfg_ch(2, 8'h00, 8'h00, 16'h2000, 8'h00, 16'd0);
    push_run("R7", 8'h00, 8'h00, 16'h2000, 8'h00, 8, fx);
    wr_seen = 0;
    wr_reg(16'h420B, 8'h04);
    while (wr_seen < 5) @(negedge clk);
    @(negedge clk);
    rd_reg(16'h4325, d);
    check("R7", "count low after 5", 48'(d), 48'hFB);
    rd_reg(16'h4326, d);
    check("R7", "count high after 5", 48'(d), 48'hFF);
    check("R7", "still busy", 48'(busy), 48'd1);
    rst_n = 1'b0;
    @(negedge clk);
    sb.delete();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", 48'(busy), 48'd0);
    expect_rd("R1", 16'h4325, 8'h00);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule